// File: doc/BRIEF.md
# I2C Bus Condition Monitor

This block listens to the two lines of an I2C bus and reports what happens at bus level. It brings the raw clock and data lines into the system clock domain and recognises the two framing conditions (a falling data line while the clock is high opens a transfer, a rising one closes it). Each recognised condition produces a one-cycle pulse. A level output shows that the bus is owned by some master. It only observes the bus and never drives either line.

While the bus is owned, the monitor counts clock rising edges to find the bit position inside the current byte. A byte occupies eight data slots plus one acknowledge slot. A framing condition is legal in two places: during the high phase of the first clock of a byte, or before any clock rise after an opening condition. A framing condition anywhere else inside a byte is a misplaced condition, and it raises a one-cycle error pulse together with the condition pulse.

The tracker is a three-state machine:
- `MON_IDLE`: bus free.
- `MON_FRAME`: at a byte boundary, where framing is legal.
- `MON_SHIFT`: inside a byte, where framing is an error.

Transitions:
- `MON_IDLE` → `MON_FRAME` on an opening condition.
- `MON_FRAME` → `MON_FRAME` on an opening condition (repeated start) or on the first clock rise.
- `MON_FRAME` → `MON_SHIFT` on the second clock rise.
- `MON_FRAME` → `MON_IDLE` on a closing condition.
- `MON_SHIFT` → `MON_SHIFT` on rises in slots 3 to 9.
- `MON_SHIFT` → `MON_FRAME` on the rise that follows the acknowledge slot, or on a misplaced opening condition.
- `MON_SHIFT` → `MON_IDLE` on a misplaced closing condition.

Top module: `i2c_bus_watch`

## Requirements
- R1: While reset is asserted and in the cycle after it is released, all pulses are low and `bus_busy` is low.
- R2: When SDA goes 1 to 0 while SCL is 1 in two consecutive synchronized samples, `cond_start` is high for exactly one cycle. This happens on the third clock edge after the line change: two synchronizer stages plus one output register.
- R3: When SDA goes 0 to 1 while SCL is 1, `cond_stop` is high for exactly one cycle, with the same latency as R2.
- R4: `bus_busy` rises in the same cycle as a `cond_start` pulse. It stays high across repeated opening conditions and falls only in the same cycle as a `cond_stop` pulse.
- R5: SDA changes made while SCL is low produce no pulse. This covers every data and acknowledge bit of a well-formed byte.
- R6: An opening condition in slots 2 to 9 of a byte raises `bus_error` in the same cycle as `cond_start`. `bus_busy` stays high, and the bit position restarts as if a fresh transfer had begun.
- R7: A closing condition in slots 2 to 9 of a byte raises `bus_error` in the same cycle as `cond_stop`, and `bus_busy` falls.
- R8: An opening or closing condition seen before any SCL rise after an opening condition, or during the first SCL high phase of a byte, raises no error. This includes the phase after a full byte and its acknowledge.
- R9: A closing condition while the bus is free gives a `cond_stop` pulse, no error, and `bus_busy` stays low.
- R10: `cond_start` and `cond_stop` are never high in the same cycle, and `bus_error` is high only together with one of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_raw | input | 1 | Bus clock line, asynchronous |
| sda_raw | input | 1 | Bus data line, asynchronous |
| cond_start | output | 1 | One-cycle pulse on an opening condition |
| cond_stop | output | 1 | One-cycle pulse on a closing condition |
| bus_busy | output | 1 | High while the bus is owned |
| bus_error | output | 1 | One-cycle pulse on a misplaced condition |

## Verification
The bench builds the block with its defaults: two synchronizer stages and eight data bits per byte, so each byte spans nine clock slots. With these values, a single nine-bit sequence reaches both ends of the slot counter. The bench drives the wrap from the acknowledge slot into the next byte, a repeated start and a closing condition at the legal boundary. It also places misplaced conditions at slot 4 and in the acknowledge slot. The scoreboard checks the order and the combination of every pulse, and separate samples check the busy level between phases.

// File: rtl/i2cmon_pkg.sv
package i2cmon_pkg;

    typedef enum logic [1:0] {
        MON_IDLE  = 2'd0,
        MON_FRAME = 2'd1,
        MON_SHIFT = 2'd2
    } mon_state_t;

    typedef struct packed {
        logic rise;
        logic open_c;
        logic close_c;
    } line_ev_t;

endpackage

// File: rtl/i2cmon_sync.sv
module i2cmon_sync #(
    parameter int STAGES = 2,
    parameter int WIDTH  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);
    logic [WIDTH-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '1;
                else        stg[s] <= d_async;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg[s] <= '1;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/i2cmon_cond.sv
module i2cmon_cond
    import i2cmon_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     scl_s,
    input  logic     sda_s,
    output line_ev_t ev
);
    logic scl_p, sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    always_comb begin
        ev.rise    = !scl_p && scl_s;
        ev.open_c  = scl_p && scl_s && sda_p && !sda_s;
        ev.close_c = scl_p && scl_s && !sda_p && sda_s;
    end

    AST_RISE_NOT_COND: assert property (@(posedge clk) disable iff (!rst_n)
        ev.rise |-> !(ev.open_c || ev.close_c)); // R10
endmodule

// File: rtl/i2cmon_fsm.sv
module i2cmon_fsm
    import i2cmon_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  line_ev_t ev,
    output logic     start_o,
    output logic     stop_o,
    output logic     busy_o,
    output logic     err_o
);
    localparam int SLOTS = DATA_BITS + 1;
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(SLOTS);
    localparam logic [CNT_W-1:0] SLOT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] SLOT_TWO  = CNT_W'(2);

    mon_state_t state_q, state_d;
    logic [CNT_W-1:0] slot_q, slot_d;

    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        unique case (state_q)
            MON_IDLE: begin
                slot_d = '0;
                if (ev.open_c) state_d = MON_FRAME;
            end
            MON_FRAME: begin
                if (ev.open_c) begin
                    slot_d = '0;
                end else if (ev.close_c) begin
                    state_d = MON_IDLE;
                    slot_d  = '0;
                end else if (ev.rise) begin
                    if (slot_q == '0) begin
                        slot_d = SLOT_ONE;
                    end else begin
                        state_d = MON_SHIFT;
                        slot_d  = SLOT_TWO;
                    end
                end
            end
            MON_SHIFT: begin
                if (ev.open_c) begin
                    state_d = MON_FRAME;
                    slot_d  = '0;
                end else if (ev.close_c) begin
                    state_d = MON_IDLE;
                    slot_d  = '0;
                end else if (ev.rise) begin
                    if (slot_q == LAST_SLOT) begin
                        state_d = MON_FRAME;
                        slot_d  = SLOT_ONE;
                    end else begin
                        slot_d = slot_q + 1'b1;
                    end
                end
            end
            default: begin
                state_d = MON_IDLE;
                slot_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= MON_IDLE;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            start_o <= 1'b0;
            stop_o  <= 1'b0;
            busy_o  <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            start_o <= ev.open_c;
            stop_o  <= ev.close_c;
            busy_o  <= (state_d != MON_IDLE);
            err_o   <= (state_q == MON_SHIFT) && (ev.open_c || ev.close_c);
        end
    end

    AST_SLOT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        slot_q <= LAST_SLOT); // R6
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o); // R2
    AST_STOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |=> !stop_o); // R3
    AST_BUSY_RISE_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> start_o); // R4
    AST_BUSY_FALL_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> stop_o); // R4
    AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o)); // R10
    AST_ERR_NEEDS_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> $past(busy_o)); // R7
    AST_ERR_START_KEEPS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && start_o) |-> busy_o); // R6
endmodule

// File: rtl/i2c_bus_watch.sv
module i2c_bus_watch
    import i2cmon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DATA_BITS   = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic cond_start,
    output logic cond_stop,
    output logic bus_busy,
    output logic bus_error
);
    logic [1:0] lines_s;
    line_ev_t   ev;

    i2cmon_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({scl_raw, sda_raw}),
        .d_sync  (lines_s)
    );

    i2cmon_cond u_cond (
        .clk   (clk),
        .rst_n (rst_n),
        .scl_s (lines_s[1]),
        .sda_s (lines_s[0]),
        .ev    (ev)
    );

    i2cmon_fsm #(.DATA_BITS(DATA_BITS)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .ev      (ev),
        .start_o (cond_start),
        .stop_o  (cond_stop),
        .busy_o  (bus_busy),
        .err_o   (bus_error)
    );

    AST_ERR_WITH_COND: assert property (@(posedge clk) disable iff (!rst_n)
        bus_error |-> (cond_start || cond_stop)); // R10
endmodule

// File: tb/i2c_bus_watch_bench.sv
module i2c_bus_watch_bench;
    localparam int HOLD = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_r = 1'b1;
    logic sda_r = 1'b1;
    logic cond_start, cond_stop, bus_busy, bus_error;

    int n_chk = 0;
    int n_fail = 0;

    logic [2:0] exp_q [$];
    string      tag_q [$];

    always #5 clk = ~clk;

    i2c_bus_watch u_i2c_bus_watch (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_raw    (scl_r),
        .sda_raw    (sda_r),
        .cond_start (cond_start),
        .cond_stop  (cond_stop),
        .bus_busy   (bus_busy),
        .bus_error  (bus_error)
    );

    // code: {error, start, stop}
    localparam logic [2:0] EV_START = 3'b010;
    localparam logic [2:0] EV_STOP  = 3'b001;
    localparam logic [2:0] EV_ESTRT = 3'b110;
    localparam logic [2:0] EV_ESTOP = 3'b101;

    task automatic expect_ev(input logic [2:0] code, input string tag);
        exp_q.push_back(code);
        tag_q.push_back(tag);
    endtask

    task automatic drive(input logic c, input logic d);
        @(negedge clk);
        scl_r = c;
        sda_r = d;
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic chk_busy(input logic exp, input string tag);
        @(negedge clk);
        n_chk++;
        if (bus_busy !== exp) begin
            n_fail++;
            $display("FAIL %s busy: actual %b expected %b", tag, bus_busy, exp);
        end
    endtask

    task automatic do_start();
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
    endtask

    task automatic do_rstart();
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b0);
        drive(1'b0, 1'b0);
    endtask

    task automatic do_stop();
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        drive(1'b1, 1'b1);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            drive(1'b0, b[i]);
            drive(1'b1, b[i]);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, input logic ack);
        send_bits(b, 8);
        drive(1'b0, ack);
        drive(1'b1, ack);
        drive(1'b0, ack);
    endtask

    // monitor: pops expected events as pulses appear
    always @(negedge clk) begin
        if (rst_n && (cond_start || cond_stop || bus_error)) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R5 unexpected pulse: actual %b expected none",
                         {bus_error, cond_start, cond_stop});
            end else begin
                automatic logic [2:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                if ({bus_error, cond_start, cond_stop} !== e) begin
                    n_fail++;
                    $display("FAIL %s pulse: actual %b expected %b", t,
                             {bus_error, cond_start, cond_stop}, e);
                end
            end
        end
    end

    initial begin
        #2_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        n_chk++;
        if ({cond_start, cond_stop, bus_busy, bus_error} !== 4'b0) begin
            n_fail++;
            $display("FAIL R1 in reset: actual %b expected 0000",
                     {cond_start, cond_stop, bus_busy, bus_error});
        end
        rst_n = 1'b1;
        chk_busy(1'b0, "R1");
        repeat (HOLD) @(negedge clk);

        // R2 R3 R5 two acknowledged bytes, then close at the legal boundary (R8)
        expect_ev(EV_START, "R2");
        do_start();
        chk_busy(1'b1, "R4");
        send_byte(8'hA5, 1'b0);
        send_byte(8'h3C, 1'b0);
        chk_busy(1'b1, "R4");
        expect_ev(EV_STOP, "R3");
        do_stop();
        chk_busy(1'b0, "R4");

        // R4 R8 repeated start after a full byte keeps ownership
        expect_ev(EV_START, "R2");
        do_start();
        send_byte(8'h5A, 1'b1);
        expect_ev(EV_START, "R8");
        do_rstart();
        chk_busy(1'b1, "R4");
        send_byte(8'hFF, 1'b0);
        expect_ev(EV_STOP, "R8");
        do_stop();
        chk_busy(1'b0, "R4");

        // R7 misplaced close at slot 4
        expect_ev(EV_START, "R2");
        do_start();
        send_bits(8'hE0, 3);
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        expect_ev(EV_ESTOP, "R7");
        drive(1'b1, 1'b1);
        chk_busy(1'b0, "R7");

        // R6 misplaced open in the acknowledge slot, then a clean byte
        expect_ev(EV_START, "R2");
        do_start();
        send_bits(8'h81, 8);
        drive(1'b0, 1'b1);
        drive(1'b1, 1'b1);
        expect_ev(EV_ESTRT, "R6");
        drive(1'b1, 1'b0);
        chk_busy(1'b1, "R6");
        drive(1'b0, 1'b0);
        send_byte(8'h42, 1'b0);
        expect_ev(EV_STOP, "R6");
        do_stop();
        chk_busy(1'b0, "R6");

        // R8 open followed at once by close, no clock rise between
        expect_ev(EV_START, "R8");
        drive(1'b1, 1'b1);
        drive(1'b1, 1'b0);
        expect_ev(EV_STOP, "R8");
        drive(1'b1, 1'b1);
        chk_busy(1'b0, "R8");

        // R9 close while the bus is free
        drive(1'b0, 1'b1);
        drive(1'b0, 1'b0);
        drive(1'b1, 1'b0);
        expect_ev(EV_STOP, "R9");
        drive(1'b1, 1'b1);
        chk_busy(1'b0, "R9");

        repeat (HOLD) @(negedge clk);
        n_chk++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R10 missing pulses: actual %0d left expected 0", exp_q.size());
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule